// File: doc/BRIEF.md
# Endpoint 0 Control and Status Register

This block holds the eight-bit control and status word for the default control endpoint of a USB device controller. Software reaches it through a plain byte write port and a read port whose width is a parameter. The endpoint engine feeds it hardware events: an OUT packet was received, a setup packet was received, a stall handshake was sent, the host took the armed IN packet. It also reports two live levels, receive-FIFO-not-empty and remote-wakeup-enabled. In return the block drives a one-cycle IN-arm strobe, a one-cycle transmit-flush strobe and a steady force-stall level.

Each bit has its own access rule. Three event flags are sticky: hardware sets them and software clears them by writing 1. Two command bits act on a write of 1 and always read back 0. One control bit is set by software and cleared when a new setup packet arrives. Two bits mirror live inputs and cannot be written. If a hardware event and a software clear reach the same flag in one cycle, the event wins, so no packet notification is ever lost.

Top module: `ep0_ctrl_stat`

## Requirements
- R1: While reset is held low and at the first cycle after it, `force_stall`, `in_ready_pulse` and `flush_tx_pulse` are 0 and every stored bit (0, 4, 5, 7) reads 0.
- R2: Bit 0 (OUT ready) reads 1 from the cycle after `hw_out_rcvd` is high. A write with data bit 0 = 1 clears it from the next cycle. A write with data bit 0 = 0 leaves it unchanged.
- R3: Bit 4 (stall sent) and bit 7 (setup active) behave as bit 0 does, set by `hw_stall_sent` and `hw_setup_rcvd` respectively.
- R4: When a hardware set event and a write-1 clear hit the same flag (bit 0, 4 or 7) in one cycle, the flag reads 1 afterwards.
- R5: Writing 1 to bit 1 while no IN packet is armed drives `in_ready_pulse` high for exactly the following cycle and arms the packet. Bit 1 always reads 0.
- R6: While an IN packet is armed, writing 1 to bit 1 gives no pulse. `hw_in_taken` disarms it. A write of 1 to bit 1 in the same cycle as `hw_in_taken` pulses and leaves the packet armed.
- R7: Every write with bit 2 = 1 drives `flush_tx_pulse` high for the following cycle. Bit 2 always reads 0.
- R8: With `STALL_AUTOCLR` = 1, writing 1 to bit 5 sets `force_stall` and bit 5 from the next cycle. Writing 0 to bit 5 leaves them set.
- R9: With `STALL_AUTOCLR` = 1, `hw_setup_rcvd` clears `force_stall` from the next cycle, even when bit 5 is written with 1 in the same cycle.
- R10: Bit 3 equals `hw_wake_en` and bit 6 equals `hw_rx_not_empty` in the same cycle. Writes to those bit positions have no effect.
- R11: Read bits `REG_W-1` down to 8 are always 0.
- R12: With `STALL_AUTOCLR` = 0, bit 5 takes the written value on every write and ignores `hw_setup_rcvd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | REG_W | Read value (combinational) |
| hw_out_rcvd | input | 1 | OUT packet received event |
| hw_setup_rcvd | input | 1 | Setup packet received event |
| hw_stall_sent | input | 1 | Stall handshake sent event |
| hw_in_taken | input | 1 | Host took the armed IN packet |
| hw_rx_not_empty | input | 1 | Receive FIFO holds data (level) |
| hw_wake_en | input | 1 | Remote wakeup enabled (level) |
| in_ready_pulse | output | 1 | One-cycle IN packet arm strobe |
| flush_tx_pulse | output | 1 | One-cycle transmit FIFO flush strobe |
| force_stall | output | 1 | Force stall handshakes (level) |

## Verification
The bench builds two instances that share the same stimulus. One uses the defaults (`REG_W` = 32, `STALL_AUTOCLR` = 1), which cover the wide reserved field and the setup-driven stall release. The other uses `REG_W` = 16 and `STALL_AUTOCLR` = 0, which brings the plain read/write stall variant and a narrower read port within reach. Directed cycles aim at same-cycle collisions: event against clear, arm against take, setup against force-stall write. A stretch of random traffic then mixes every input.

// File: rtl/ep0cs_pkg.sv
package ep0cs_pkg;
   localparam int unsigned CS_BITS       = 8;
   localparam int unsigned N_FLAGS       = 3;
   // bit positions decoded by software
   localparam int unsigned B_OUT_RDY     = 0;
   localparam int unsigned B_IN_ARM      = 1;
   localparam int unsigned B_FLUSH       = 2;
   localparam int unsigned B_WAKE        = 3;
   localparam int unsigned B_STALL_SENT  = 4;
   localparam int unsigned B_FORCE_STALL = 5;
   localparam int unsigned B_RX_NE       = 6;
   localparam int unsigned B_SETUP       = 7;

   typedef struct packed {
      logic setup;
      logic rx_ne;
      logic force_stall;
      logic stall_sent;
      logic wake;
      logic flush;
      logic in_arm;
      logic out_rdy;
   } cs_view_t;

   function automatic int unsigned flag_pos(input int unsigned idx);
      case (idx)
         0:       return B_OUT_RDY;
         1:       return B_STALL_SENT;
         default: return B_SETUP;
      endcase
   endfunction
endpackage

// File: rtl/ep0cs_flag.sv
module ep0cs_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic sw_clr,
   output logic q
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_wins
         always_comb nxt = hw_set | (q & ~sw_clr);
      end else begin : g_clr_wins
         always_comb nxt = ~sw_clr & (hw_set | q);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/ep0cs_in_arm.sv
module ep0cs_in_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_req,
   input  logic taken,
   output logic pulse
);
   logic armed;
   logic free;

   assign free = ~armed | taken;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         pulse <= 1'b0;
      end else begin
         armed <= arm_req | (armed & ~taken);
         pulse <= arm_req & free;
      end
   end
endmodule

// File: rtl/ep0cs_stall_ctl.sv
module ep0cs_stall_ctl #(
   parameter bit AUTOCLR = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_bit,
   input  logic setup,
   output logic q
);
   logic nxt;

   generate
      if (AUTOCLR) begin : g_auto
         always_comb nxt = ~setup & (q | (wr_en & wr_bit));
      end else begin : g_plain
         logic unused_setup;
         assign unused_setup = setup;
         always_comb nxt = wr_en ? wr_bit : q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end
endmodule

// File: rtl/ep0_ctrl_stat.sv
module ep0_ctrl_stat
   import ep0cs_pkg::*;
#(
   parameter int unsigned REG_W         = 32,
   parameter bit          STALL_AUTOCLR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             hw_out_rcvd,
   input  logic             hw_setup_rcvd,
   input  logic             hw_stall_sent,
   input  logic             hw_in_taken,
   input  logic             hw_rx_not_empty,
   input  logic             hw_wake_en,
   output logic             in_ready_pulse,
   output logic             flush_tx_pulse,
   output logic             force_stall
);
   localparam int unsigned PAD_W = REG_W - CS_BITS;

   generate
      if (REG_W < CS_BITS) begin : g_bad_width
         $error("ep0_ctrl_stat: REG_W must be at least 8");
      end
   endgenerate

   logic [N_FLAGS-1:0] flag_set;
   logic [N_FLAGS-1:0] flag_q;
   logic               flush_q;
   cs_view_t           view;

   assign flag_set[0] = hw_out_rcvd;
   assign flag_set[1] = hw_stall_sent;
   assign flag_set[2] = hw_setup_rcvd;

   generate
      for (genvar i = 0; i < N_FLAGS; i++) begin : g_flag
         ep0cs_flag #(.SET_WINS(1'b1)) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (flag_set[i]),
            .sw_clr (wr_en & wr_data[flag_pos(i)]),
            .q      (flag_q[i])
         );
      end
   endgenerate

   ep0cs_in_arm u_in_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_req (wr_en & wr_data[B_IN_ARM]),
      .taken   (hw_in_taken),
      .pulse   (in_ready_pulse)
   );

   ep0cs_stall_ctl #(.AUTOCLR(STALL_AUTOCLR)) u_stall (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_bit (wr_data[B_FORCE_STALL]),
      .setup  (hw_setup_rcvd),
      .q      (force_stall)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) flush_q <= 1'b0;
      else        flush_q <= wr_en & wr_data[B_FLUSH];
   end
   assign flush_tx_pulse = flush_q;

   always_comb begin
      view             = '0;
      view.out_rdy     = flag_q[0];
      view.stall_sent  = flag_q[1];
      view.setup       = flag_q[2];
      view.force_stall = force_stall;
      view.wake        = hw_wake_en;
      view.rx_ne       = hw_rx_not_empty;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, view};
      end else begin : g_nopad
         assign rd_data = view;
      end
   endgenerate
endmodule

// File: rtl/ep0cs_chk.sv
module ep0cs_chk #(
   parameter int unsigned REG_W         = 32,
   parameter bit          STALL_AUTOCLR = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [7:0]       wr_data,
   input logic [REG_W-1:0] rd_data,
   input logic             hw_out_rcvd,
   input logic             hw_setup_rcvd,
   input logic             hw_stall_sent,
   input logic             in_ready_pulse,
   input logic             flush_tx_pulse,
   input logic             force_stall
);
   // R2
   out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hw_out_rcvd |=> rd_data[0]);

   // R3
   stall_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[4] && !hw_stall_sent) |=> !rd_data[4]);

   // R4
   set_over_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_setup_rcvd && wr_en && wr_data[7]) |=> rd_data[7]);

   // R5
   in_pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready_pulse |-> $past(wr_en && wr_data[1]));

   // R5
   cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[2:1] == 2'b00);

   // R7
   flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[2]) |=> flush_tx_pulse);

   generate
      if (STALL_AUTOCLR) begin : g_auto
         // R9
         setup_unstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_setup_rcvd |=> !force_stall);
      end else begin : g_plain
         // R12
         stall_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> (force_stall == $past(wr_data[5])));
      end
   endgenerate
endmodule

bind ep0_ctrl_stat ep0cs_chk #(.REG_W(REG_W), .STALL_AUTOCLR(STALL_AUTOCLR)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_data        (wr_data),
   .rd_data        (rd_data),
   .hw_out_rcvd    (hw_out_rcvd),
   .hw_setup_rcvd  (hw_setup_rcvd),
   .hw_stall_sent  (hw_stall_sent),
   .in_ready_pulse (in_ready_pulse),
   .flush_tx_pulse (flush_tx_pulse),
   .force_stall    (force_stall)
);

// File: tb/tb_ep0_ctrl_stat.sv
`timescale 1ns/1ps
module tb_ep0_ctrl_stat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        ev_out = 1'b0, ev_setup = 1'b0, ev_stall = 1'b0, ev_taken = 1'b0;
   logic        lv_rxne = 1'b0, lv_wake = 1'b0;
   logic [31:0] rd_a;
   logic [15:0] rd_b;
   logic        inp_a, fl_a, fs_a, inp_b, fl_b, fs_b;
   int          checks = 0, fails = 0;
   bit          done = 0;

   // reference model state
   bit m_out, m_sst, m_set, m_fs, m_fs2, m_pend, m_inp, m_fl;

   always #2 clk = ~clk;

   ep0_ctrl_stat dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_a),
      .hw_out_rcvd(ev_out), .hw_setup_rcvd(ev_setup), .hw_stall_sent(ev_stall),
      .hw_in_taken(ev_taken), .hw_rx_not_empty(lv_rxne), .hw_wake_en(lv_wake),
      .in_ready_pulse(inp_a), .flush_tx_pulse(fl_a), .force_stall(fs_a));

   ep0_ctrl_stat #(.REG_W(16), .STALL_AUTOCLR(1'b0)) dut_rw (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_b),
      .hw_out_rcvd(ev_out), .hw_setup_rcvd(ev_setup), .hw_stall_sent(ev_stall),
      .hw_in_taken(ev_taken), .hw_rx_not_empty(lv_rxne), .hw_wake_en(lv_wake),
      .in_ready_pulse(inp_b), .flush_tx_pulse(fl_b), .force_stall(fs_b));

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [7:0] ea, eb;
      ea = {m_set, lv_rxne, m_fs,  m_sst, lv_wake, 2'b00, m_out};
      eb = {m_set, lv_rxne, m_fs2, m_sst, lv_wake, 2'b00, m_out};
      chk(tag, "rd_data", rd_a, {24'h0, ea});
      chk(tag, "in_ready_pulse", inp_a, m_inp);
      chk(tag, "flush_tx_pulse", fl_a, m_fl);
      chk(tag, "force_stall", fs_a, m_fs);
      chk({"R12 via ", tag}, "rd_data", rd_b, {8'h0, eb});
      chk({"R12 via ", tag}, "force_stall", fs_b, m_fs2);
      chk({"R12 via ", tag}, "pulses", {inp_b, fl_b}, {m_inp, m_fl});
   endtask

   task automatic model_step();
      bit arm;
      arm    = wr_en & wr_data[1];
      m_inp  = arm & (!m_pend | ev_taken);
      m_pend = arm | (m_pend & !ev_taken);
      m_fl   = wr_en & wr_data[2];
      m_out  = ev_out   | (m_out & !(wr_en & wr_data[0]));
      m_sst  = ev_stall | (m_sst & !(wr_en & wr_data[4]));
      m_set  = ev_setup | (m_set & !(wr_en & wr_data[7]));
      m_fs   = ev_setup ? 1'b0 : (m_fs | (wr_en & wr_data[5]));
      if (wr_en) m_fs2 = wr_data[5];
   endtask

   // ev = {wake, rxne, taken, stall, setup, out}; called at a falling edge
   task automatic cyc(input bit we, input logic [7:0] wd, input logic [5:0] ev, input string tag);
      wr_en = we; wr_data = wd;
      {lv_wake, lv_rxne, ev_taken, ev_stall, ev_setup, ev_out} = ev;
      #1 compare(tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   initial begin
      #800000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      compare("R1");
      @(negedge clk);
      rst_n = 1'b1;
      cyc(0, 8'h00, 6'b000000, "R1");
      // R10: live mirrors, writes ignored
      cyc(0, 8'h00, 6'b110000, "R10");
      cyc(1, 8'h48, 6'b010000, "R10");
      cyc(0, 8'h00, 6'b100000, "R10");
      // R2
      cyc(0, 8'h00, 6'b000001, "R2");
      cyc(0, 8'h00, 6'b000000, "R2");
      cyc(1, 8'h00, 6'b000000, "R2");
      cyc(1, 8'h01, 6'b000000, "R2");
      cyc(0, 8'h00, 6'b000000, "R2");
      // R3
      cyc(0, 8'h00, 6'b000100, "R3");
      cyc(0, 8'h00, 6'b000010, "R3");
      cyc(1, 8'h6E, 6'b000000, "R3");
      cyc(1, 8'h90, 6'b000000, "R3");
      cyc(0, 8'h00, 6'b000000, "R3");
      // R4: set wins
      cyc(1, 8'h91, 6'b000111, "R4");
      cyc(0, 8'h00, 6'b000000, "R4");
      cyc(1, 8'h91, 6'b000000, "R4");
      // R5
      cyc(1, 8'h02, 6'b000000, "R5");
      cyc(0, 8'h00, 6'b000000, "R5");
      cyc(0, 8'h00, 6'b000000, "R5");
      // R6
      cyc(1, 8'h02, 6'b000000, "R6");
      cyc(0, 8'h00, 6'b000000, "R6");
      cyc(0, 8'h00, 6'b001000, "R6");
      cyc(1, 8'h02, 6'b000000, "R6");
      cyc(1, 8'h02, 6'b001000, "R6");
      cyc(1, 8'h02, 6'b000000, "R6");
      cyc(0, 8'h00, 6'b001000, "R6");
      // R7
      cyc(1, 8'h04, 6'b000000, "R7");
      cyc(1, 8'h04, 6'b000000, "R7");
      cyc(0, 8'h00, 6'b000000, "R7");
      cyc(0, 8'h00, 6'b000000, "R7");
      // R8
      cyc(1, 8'h20, 6'b000000, "R8");
      cyc(0, 8'h00, 6'b000000, "R8");
      cyc(1, 8'h00, 6'b000000, "R8");
      cyc(0, 8'h00, 6'b000000, "R8");
      // R9
      cyc(0, 8'h00, 6'b000010, "R9");
      cyc(0, 8'h00, 6'b000000, "R9");
      cyc(1, 8'h20, 6'b000000, "R9");
      cyc(1, 8'h20, 6'b000010, "R9");
      cyc(1, 8'h80, 6'b000000, "R9");
      cyc(0, 8'h00, 6'b000000, "R9");
      // R11: all-ones write, upper read bits stay 0
      cyc(1, 8'hFF, 6'b110000, "R11");
      cyc(0, 8'h00, 6'b111000, "R11");
      // mixed random traffic, collisions across R4 and R6
      for (int i = 0; i < 400; i++)
         cyc(($urandom % 3) == 0, 8'($urandom), 6'($urandom), "R4");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule